// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Carry and Zero Flags

This block is the datapath unit of a small accumulator-style controller core. Each cycle it takes an operation code, a destination operand and a second operand. The second operand has already been chosen upstream, either from a register or from an instruction constant. The block is purely combinational. It returns the 8-bit value to write back, a write-enable for the destination register, and the next values of the carry and zero flags. The caller latches these flags into its own flag register.

The current carry flag is an input. This lets add-with-carry and subtract-with-borrow be chained byte by byte to build wider arithmetic. Two operations, TEST and COMPARE, only move the flags: TEST ANDs the operands, and COMPARE subtracts them. Both assert no write. Code values outside the defined set leave both flags exactly as they came in and write nothing.

Top module: `alu8_core`

## Requirements
- R1: Codes 0x0 (AND), 0x1 (OR) and 0x2 (XOR) return the bitwise result of the two operands, assert the write-enable, and drive the next carry to 0.
- R2: Code 0x4 (ADD) returns the low 8 bits of A+B. The next carry is bit 8 of that sum, and the write-enable is asserted.
- R3: Code 0x5 (add with carry) returns the low 8 bits of A+B+carry_in. The next carry is bit 8 of that sum, so feeding it back chains multi-byte addition.
- R4: Code 0x6 (SUB) returns (A-B) mod 256. The next carry is 1 exactly when A < B (a borrow), and the write-enable is asserted.
- R5: Code 0x7 (subtract with borrow) returns (A-B-carry_in) mod 256. The next carry is 1 exactly when A < B+carry_in, so chained multi-byte subtraction works.
- R6: Code 0x3 (TEST) presents A AND B on the result, deasserts the write-enable, and sets the next carry to the odd parity of that AND value (1 when it holds an odd number of ones).
- R7: Code 0x8 (COMPARE) presents (A-B) mod 256 on the result, deasserts the write-enable, and sets the next carry to 1 exactly when A < B.
- R8: For every code 0x0 to 0x8, the next zero flag is 1 exactly when the 8-bit result is 0x00. The incoming zero flag never affects it, including for the chained codes 0x5 and 0x7.
- R9: Codes 0x9 to 0xF drive the result to 0x00, deassert the write-enable, and pass the incoming carry and zero flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Destination operand A |
| opb_i | input | 8 | Second operand B (register or constant) |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| res_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Write-enable for the destination register |
| carry_o | output | 1 | Next carry flag |
| zero_o | output | 1 | Next zero flag |

## Verification
The two functions that can fall in the same evaluation are the carry-in chaining of codes 0x5 and 0x7 and the per-byte zero decision. For example, 0xFF+0x00 with carry in gives a zero byte together with a carry out, and 0x00-0x00 with borrow in wraps to 0xFF with a borrow. The sweep drives every A value against a spread of B values, with both carry-in levels and both zero-in levels. This shows that neither flag leaks into the other and that the incoming zero never reaches the outgoing one. Three-byte add and subtract chains then feed carry_o back into carry_i. Their concatenated results and final flags are judged against the full 24-bit arithmetic done in the bench.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_AND  = 4'h0;
  localparam logic [OP_W-1:0] OP_OR   = 4'h1;
  localparam logic [OP_W-1:0] OP_XOR  = 4'h2;
  localparam logic [OP_W-1:0] OP_TEST = 4'h3;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h4;
  localparam logic [OP_W-1:0] OP_ADDC = 4'h5;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h6;
  localparam logic [OP_W-1:0] OP_SUBC = 4'h7;
  localparam logic [OP_W-1:0] OP_CMP  = 4'h8;
  localparam logic [OP_W-1:0] OP_LAST = OP_CMP;

  typedef enum logic [1:0] {
    LFN_AND = 2'd0,
    LFN_OR  = 2'd1,
    LFN_XOR = 2'd2
  } lfn_e;

  typedef struct packed {
    logic defined;
    logic is_logic;
    logic is_test;
    logic is_sub;
    logic use_cin;
    logic no_wb;
    lfn_e lfn;
  } op_ctl_t;
endpackage

// File: rtl/alu8_decode.sv
`timescale 1ns/1ps
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_ctl_t         ctl_o
);
  always_comb begin
    ctl_o          = '0;
    ctl_o.lfn      = LFN_AND;
    ctl_o.defined  = (op_i <= OP_LAST);
    ctl_o.is_logic = (op_i <= OP_TEST);
    ctl_o.is_test  = (op_i == OP_TEST);
    ctl_o.is_sub   = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    ctl_o.use_cin  = (op_i == OP_ADDC) || (op_i == OP_SUBC);
    ctl_o.no_wb    = (op_i == OP_TEST) || (op_i == OP_CMP) || (op_i > OP_LAST);
    if (op_i == OP_OR)       ctl_o.lfn = LFN_OR;
    else if (op_i == OP_XOR) ctl_o.lfn = LFN_XOR;
    else                     ctl_o.lfn = LFN_AND;
  end
endmodule

// File: rtl/alu8_logic_unit.sv
`timescale 1ns/1ps
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  lfn_e         fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  function automatic logic [W-1:0] f_bitwise(input lfn_e fn,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    logic [W-1:0] r;
    case (fn)
      LFN_OR:  r = a | b;
      LFN_XOR: r = a ^ b;
      default: r = a & b;
    endcase
    return r;
  endfunction

  assign y_o = f_bitwise(fn_i, a_i, b_i);
endmodule

// File: rtl/alu8_arith_unit.sv
`timescale 1ns/1ps
module alu8_arith_unit
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         sub_i,
  input  logic         use_cin_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         cy_o
);
  localparam int WX = W + 1;

  // One adder serves both directions: subtraction adds ~B with an
  // inverted carry-in, and the carry out is inverted into a borrow.
  function automatic logic [WX-1:0] f_addsub(input logic sub,
                                             input logic cin,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    logic [W-1:0]  bb;
    logic          ci;
    logic [WX-1:0] s;
    bb = sub ? ~b : b;
    ci = sub ? ~cin : cin;
    s  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, ci};
    s[W] = sub ? ~s[W] : s[W];
    return s;
  endfunction

  logic          cin_eff;
  logic [WX-1:0] sum_w;

  assign cin_eff = use_cin_i & cin_i;
  assign sum_w   = f_addsub(sub_i, cin_eff, a_i, b_i);
  assign y_o     = sum_w[W-1:0];
  assign cy_o    = sum_w[W];
endmodule

// File: rtl/alu8_flag_unit.sv
`timescale 1ns/1ps
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  op_ctl_t      ctl_i,
  input  logic [W-1:0] logic_val_i,
  input  logic [W-1:0] arith_val_i,
  input  logic         arith_cy_i,
  input  logic         carry_i,
  input  logic         zero_i,
  output logic [W-1:0] res_o,
  output logic         wr_en_o,
  output logic         carry_o,
  output logic         zero_o
);
  function automatic logic f_odd_parity(input logic [W-1:0] v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < W; i++) p = p ^ v[i];
    return p;
  endfunction

  logic [W-1:0] sel_val;

  always_comb begin
    if (!ctl_i.defined)      sel_val = '0;
    else if (ctl_i.is_logic) sel_val = logic_val_i;
    else                     sel_val = arith_val_i;
  end

  always_comb begin
    if (!ctl_i.defined)      carry_o = carry_i;
    else if (ctl_i.is_test)  carry_o = f_odd_parity(logic_val_i);
    else if (ctl_i.is_logic) carry_o = 1'b0;
    else                     carry_o = arith_cy_i;
  end

  assign zero_o  = ctl_i.defined ? (sel_val == '0) : zero_i;
  assign res_o   = sel_val;
  assign wr_en_o = ctl_i.defined & ~ctl_i.no_wb;
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    opa_i,
  input  logic [W-1:0]    opb_i,
  input  logic            carry_i,
  input  logic            zero_i,
  output logic [W-1:0]    res_o,
  output logic            wr_en_o,
  output logic            carry_o,
  output logic            zero_o
);
  op_ctl_t      ctl;
  logic [W-1:0] logic_val;
  logic [W-1:0] arith_val;
  logic         arith_cy;

  alu8_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  alu8_logic_unit #(.W(W)) u_log (
    .fn_i (ctl.lfn),
    .a_i  (opa_i),
    .b_i  (opb_i),
    .y_o  (logic_val)
  );

  alu8_arith_unit #(.W(W)) u_ari (
    .sub_i     (ctl.is_sub),
    .use_cin_i (ctl.use_cin),
    .cin_i     (carry_i),
    .a_i       (opa_i),
    .b_i       (opb_i),
    .y_o       (arith_val),
    .cy_o      (arith_cy)
  );

  alu8_flag_unit #(.W(W)) u_flg (
    .ctl_i       (ctl),
    .logic_val_i (logic_val),
    .arith_val_i (arith_val),
    .arith_cy_i  (arith_cy),
    .carry_i     (carry_i),
    .zero_i      (zero_i),
    .res_o       (res_o),
    .wr_en_o     (wr_en_o),
    .carry_o     (carry_o),
    .zero_o      (zero_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    opa_i,
  input logic [W-1:0]    opb_i,
  input logic            carry_i,
  input logic            zero_i,
  input logic [W-1:0]    res_o,
  input logic            wr_en_o,
  input logic            carry_o,
  input logic            zero_o,
  input logic [W-1:0]    logic_val,
  input logic [W-1:0]    arith_val,
  input logic            arith_cy
);
  logic [W:0] add_ref;
  assign add_ref = {1'b0, opa_i} + {1'b0, opb_i};

  always_comb begin
    if (op_i <= OP_XOR) begin
      AST_LOGIC_CARRY_CLEAR: assert (!carry_o && wr_en_o && res_o == logic_val) else $error("logic carry"); // R1
    end
    if (op_i == OP_ADD) begin
      AST_ADD_SUM: assert ({carry_o, res_o} == add_ref) else $error("add sum"); // R2
    end
    if (op_i == OP_SUB || op_i == OP_CMP) begin
      AST_SUB_BORROW: assert (carry_o == (opa_i < opb_i)) else $error("borrow"); // R4
    end
    if (op_i == OP_TEST) begin
      AST_TEST_PARITY: assert (!wr_en_o && carry_o == ^(opa_i & opb_i)) else $error("test parity"); // R6
    end
    if (op_i == OP_CMP) begin
      AST_CMP_NO_WRITE: assert (!wr_en_o && res_o == arith_val && carry_o == arith_cy) else $error("cmp"); // R7
    end
    if (op_i <= OP_LAST) begin
      AST_ZERO_MATCH: assert (zero_o == (res_o == '0)) else $error("zero"); // R8
    end
    if (op_i > OP_LAST) begin
      AST_UNDEF_HOLD: assert (!wr_en_o && res_o == '0 && carry_o == carry_i && zero_o == zero_i) else $error("undef"); // R9
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .op_i      (op_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .carry_i   (carry_i),
  .zero_i    (zero_i),
  .res_o     (res_o),
  .wr_en_o   (wr_en_o),
  .carry_o   (carry_o),
  .zero_o    (zero_o),
  .logic_val (logic_val),
  .arith_val (arith_val),
  .arith_cy  (arith_cy)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       ci, zi;
  logic [7:0] res;
  logic       we, co, zo;

  int n_cmp  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u0 (
    .op_i(op), .opa_i(a), .opb_i(b), .carry_i(ci), .zero_i(zi),
    .res_o(res), .wr_en_o(we), .carry_o(co), .zero_o(zo)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s op=%0h a=%02h b=%02h ci=%0b zi=%0b actual=%0h expected=%0h",
               tag, op, a, b, ci, zi, got, exp);
    end
  endtask

  // Reference computed from the requirement arithmetic
  task automatic expect_all(output int er, output int ew, output int ec,
                            output int ez, output string tag);
    int ia, ib, ic, t, ones;
    ia = a; ib = b; ic = ci;
    ew = 1; ec = 0;
    case (op)
      4'h0: begin er = ia & ib; tag = "R1"; end
      4'h1: begin er = ia | ib; tag = "R1"; end
      4'h2: begin er = ia ^ ib; tag = "R1"; end
      4'h3: begin
        er = ia & ib; ew = 0; tag = "R6";
        ones = 0;
        for (int k = 0; k < 8; k++) ones += (er >> k) & 1;
        ec = ones % 2;
      end
      4'h4: begin t = ia + ib;      er = t % 256; ec = (t > 255); tag = "R2"; end
      4'h5: begin t = ia + ib + ic; er = t % 256; ec = (t > 255); tag = "R3"; end
      4'h6: begin t = ia - ib;      er = (t + 256) % 256; ec = (t < 0); tag = "R4"; end
      4'h7: begin t = ia - ib - ic; er = (t + 512) % 256; ec = (t < 0); tag = "R5"; end
      4'h8: begin t = ia - ib;      er = (t + 256) % 256; ec = (t < 0); ew = 0; tag = "R7"; end
      default: begin er = 0; ew = 0; ec = ic; tag = "R9"; end
    endcase
    if (op <= 4'h8) ez = (er == 0);
    else            ez = zi;
  endtask

  task automatic apply_and_check();
    int er, ew, ec, ez;
    string tag;
    #1;
    expect_all(er, ew, ec, ez, tag);
    chk({tag, " result"}, res, er);
    chk({tag, " write"}, we, ew);
    chk({tag, " carry"}, co, ec);
    chk((op <= 4'h8) ? "R8 zero" : "R9 zero", zo, ez);
  endtask

  // Three-byte chains: carry_o is fed back as carry_i
  task automatic chain(input bit sub, input int x, input int y);
    int r, ref_v, cflag;
    bit carry;
    r = 0; carry = 1'b0;
    for (int k = 0; k < 3; k++) begin
      op = (k == 0) ? (sub ? 4'h6 : 4'h4) : (sub ? 4'h7 : 4'h5);
      a  = 8'((x >> (8*k)) & 255);
      b  = 8'((y >> (8*k)) & 255);
      ci = carry; zi = 1'b1;
      #1;
      r = r | (int'(res) << (8*k));
      carry = co;
    end
    if (sub) begin ref_v = (x - y) & 24'hFFFFFF; cflag = (x < y); end
    else     begin ref_v = (x + y) & 24'hFFFFFF; cflag = ((x + y) > 24'hFFFFFF); end
    chk(sub ? "R5 chain value" : "R3 chain value", r, ref_v);
    chk(sub ? "R5 chain carry" : "R3 chain carry", int'(carry), cflag);
  endtask

  initial begin
    op = 4'h0; a = 8'h00; b = 8'h00; ci = 1'b0; zi = 1'b0;
    @(negedge clk);
    // Idle state with all inputs low: AND of zeros
    chk("R1 reset result", res, 0);
    chk("R1 reset write", we, 1);
    chk("R1 reset carry", co, 0);
    chk("R8 reset zero", zo, 1);

    // Corner: carry-in produces zero byte and carry out together
    op = 4'h5; a = 8'hFF; b = 8'h00; ci = 1'b1; zi = 1'b0; #1;
    chk("R3 wrap result", res, 0); chk("R3 wrap carry", co, 1); chk("R8 wrap zero", zo, 1);
    // Corner: borrow-in on equal operands wraps with borrow
    op = 4'h7; a = 8'h00; b = 8'h00; ci = 1'b1; zi = 1'b1; #1;
    chk("R5 wrap result", res, 8'hFF); chk("R5 wrap carry", co, 1); chk("R8 stale zero", zo, 0);
    // Compare equal: zero set, no borrow, no write
    op = 4'h8; a = 8'h5A; b = 8'h5A; ci = 1'b1; zi = 1'b0; #1;
    chk("R7 equal zero", zo, 1); chk("R7 equal carry", co, 0); chk("R7 equal write", we, 0);

    chain(1'b0, 24'hFFFFFF, 24'h000001);
    chain(1'b0, 24'h12F0FF, 24'h340F01);
    chain(1'b1, 24'h000000, 24'h000001);
    chain(1'b1, 24'h560000, 24'h120001);

    // Sweep: all codes, all A, spread of B, both flag-in levels
    for (int o = 0; o < 16; o++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int j = 0; j < 18; j++) begin
          for (int f = 0; f < 4; f++) begin
            op = 4'(o);
            a  = 8'(ai);
            b  = (j < 16) ? 8'(j * 17) : ((j == 16) ? 8'h01 : 8'h80);
            ci = f[0];
            zi = f[1];
            apply_and_check();
          end
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG && !done) begin
      n_cmp  = n_cmp + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule